// File: doc/BRIEF.md
# Dual-Bus Bidirectional Storage Register

This block holds a small word between two bidirectional buses, called A and B here. Each stored bit has a terminal on both buses. On a rising clock edge the register can take its new contents from bus A, from bus B, or from both. In the last case the two buses are merged with a bitwise OR, so a 1 on either bus sets that bit. When neither bus is selected, the register keeps its value.

The drive of the stored word onto each bus is controlled on its own. For each bus, a high-impedance control releases the bus, and clearing that control lets the register drive it. A high level on the clear input empties the register at once, without waiting for the clock.

Each bus is modelled as three signals: an input vector, an output vector and an output-enable vector. A pad ring or tristate wrapper above this block joins them into one bidirectional wire. When a driven bus is also chosen as the load source, the register takes the value on that bus's input vector.

Top module: `dbr_dual_bus_reg`

## Requirements
- R1: The stored word changes only on a rising edge of `clk`, or when `clr` goes high. Load inputs that are applied between edges leave `a_out` and `b_out` unchanged until the next rising edge.
- R2: A high level on `clr` sets every stored bit to 0 at once, with no clock edge needed. While `clr` is high, no rising edge loads the register, whatever the load selects are.
- R3: All bits of `a_oe` are 1 when `a_hiz` is 0, and all bits are 0 when `a_hiz` is 1. This holds whatever the load selects and `clr` are doing.
- R4: All bits of `b_oe` are 1 when `b_hiz` is 0, and all bits are 0 when `b_hiz` is 1. This holds whatever the load selects and `clr` are doing.
- R5: With `a_ld_n`=0 and `b_ld_n`=1, a rising edge stores `a_in`.
- R6: With `a_ld_n`=1 and `b_ld_n`=0, a rising edge stores `b_in`.
- R7: With `a_ld_n`=0 and `b_ld_n`=0, a rising edge stores the bitwise OR of `a_in` and `b_in`.
- R8: With `a_ld_n`=1 and `b_ld_n`=1, a rising edge leaves the stored word unchanged, whatever the bus inputs and high-impedance controls are.
- R9: `a_out` and `b_out` always both carry the stored word, whether or not their enables are set. After reset both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| clr | input | 1 | Asynchronous clear, active high |
| a_ld_n | input | 1 | Select bus A as load source, active low |
| b_ld_n | input | 1 | Select bus B as load source, active low |
| a_hiz | input | 1 | Release bus A (high impedance) when 1 |
| b_hiz | input | 1 | Release bus B (high impedance) when 1 |
| a_in | input | WIDTH | Value seen on bus A |
| b_in | input | WIDTH | Value seen on bus B |
| a_out | output | WIDTH | Stored word offered to bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_out | output | WIDTH | Stored word offered to bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
On every clock cycle, the assertions check four things:
- a cleared register reads zero;
- each of the three load selections stores the word the requirements give for it;
- the hold selection keeps the word unchanged;
- each output-enable vector is all ones or all zeros.

Only the bench's scenarios can show the rest: that a clear raised between edges empties the register at once, that load inputs applied between edges do nothing before the edge, and that the OR merge works on mixed bit patterns. The scenarios also show the exact polarity of each enable against its high-impedance control, and that both output vectors carry the same word.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
package dbr_pkg;

   typedef enum logic [1:0] {
      SRC_HOLD = 2'b00,
      SRC_A    = 2'b01,
      SRC_B    = 2'b10,
      SRC_BOTH = 2'b11
   } dbr_src_e;

   // Active-low selects map straight onto the source code.
   function automatic dbr_src_e decode_src(input logic a_sel_n, input logic b_sel_n);
      return dbr_src_e'({~b_sel_n, ~a_sel_n});
   endfunction

endpackage

// File: rtl/dbr_src_sel.sv
`timescale 1ns/1ps
module dbr_src_sel
   import dbr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             a_sel_n,
   input  logic             b_sel_n,
   input  logic [WIDTH-1:0] a_val,
   input  logic [WIDTH-1:0] b_val,
   output logic             load,
   output logic [WIDTH-1:0] nxt
);

   dbr_src_e src;

   always_comb begin
      src  = decode_src(a_sel_n, b_sel_n);
      load = (src != SRC_HOLD);
      unique case (src)
         SRC_A:    nxt = a_val;
         SRC_B:    nxt = b_val;
         SRC_BOTH: nxt = a_val | b_val;
         default:  nxt = '0;
      endcase
   end

endmodule

// File: rtl/dbr_bit_cell.sv
`timescale 1ns/1ps
module dbr_bit_cell (
   input  logic clk,
   input  logic clr,
   input  logic load,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or posedge clr) begin
      if (clr)
         q <= 1'b0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/dbr_drive.sv
`timescale 1ns/1ps
module dbr_drive #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             hiz,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] out,
   output logic [WIDTH-1:0] oe
);

   assign out = stored;
   assign oe  = {WIDTH{~hiz}};

   // R3/R4: every enable bit agrees, so a bus is driven whole or released whole.
   p_oe_uniform_r3: assert property (@(posedge clk) disable iff (clr)
      ($countones(oe) == 0) || ($countones(oe) == WIDTH));

endmodule

// File: rtl/dbr_dual_bus_reg.sv
`timescale 1ns/1ps
module dbr_dual_bus_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             a_ld_n,
   input  logic             b_ld_n,
   input  logic             a_hiz,
   input  logic             b_hiz,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);

   if (WIDTH < 1) begin : g_bad_width
      $error("dbr_dual_bus_reg: WIDTH must be at least 1");
   end

   logic             load;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] stored;

   dbr_src_sel #(.WIDTH(WIDTH)) u_sel (
      .a_sel_n (a_ld_n),
      .b_sel_n (b_ld_n),
      .a_val   (a_in),
      .b_val   (b_in),
      .load    (load),
      .nxt     (nxt)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      dbr_bit_cell u_cell (
         .clk  (clk),
         .clr  (clr),
         .load (load),
         .d    (nxt[i]),
         .q    (stored[i])
      );
   end

   dbr_drive #(.WIDTH(WIDTH)) u_drv_a (
      .clk    (clk),
      .clr    (clr),
      .hiz    (a_hiz),
      .stored (stored),
      .out    (a_out),
      .oe     (a_oe)
   );

   dbr_drive #(.WIDTH(WIDTH)) u_drv_b (
      .clk    (clk),
      .clr    (clr),
      .hiz    (b_hiz),
      .stored (stored),
      .out    (b_out),
      .oe     (b_oe)
   );

   // R2: a clear seen at an edge means the word is already zero.
   p_clear_zero_r2: assert property (@(posedge clk)
      clr |-> (a_out == '0));

   // R5
   p_load_a_r5: assert property (@(posedge clk) disable iff (clr)
      (!a_ld_n && b_ld_n) |=> (a_out == $past(a_in)));

   // R6
   p_load_b_r6: assert property (@(posedge clk) disable iff (clr)
      (a_ld_n && !b_ld_n) |=> (b_out == $past(b_in)));

   // R7
   p_load_or_r7: assert property (@(posedge clk) disable iff (clr)
      (!a_ld_n && !b_ld_n) |=> (a_out == ($past(a_in) | $past(b_in))));

   // R8
   p_hold_r8: assert property (@(posedge clk) disable iff (clr)
      (a_ld_n && b_ld_n) |=> $stable(b_out));

endmodule

// File: tb/dbr_dual_bus_reg_tb.sv
`timescale 1ns/1ps
module dbr_dual_bus_reg_tb;

   localparam int W = 4;
   localparam int NV = 10;

   // {a_ld_n, b_ld_n, a_hiz, b_hiz, a_in, b_in, expected word}
   localparam logic [15:0] VEC [NV] = '{
      16'b0_1_0_1_1010_0000_1010,
      16'b1_0_1_0_0000_0101_0101,
      16'b1_1_0_0_1111_1111_0101,
      16'b1_1_1_1_0000_0000_0101,
      16'b0_0_1_1_1100_1010_1110,
      16'b0_0_0_1_0001_0000_0001,
      16'b0_1_1_0_0000_1111_0000,
      16'b0_0_1_0_0000_1001_1001,
      16'b1_0_0_1_1111_0110_0110,
      16'b1_1_0_1_1001_1001_0110
   };

   logic         clk = 1'b0;
   logic         clr = 1'b1;
   logic         a_ld_n = 1'b1, b_ld_n = 1'b1, a_hiz = 1'b1, b_hiz = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   dbr_dual_bus_reg #(.WIDTH(W)) u_dut (
      .clk(clk), .clr(clr), .a_ld_n(a_ld_n), .b_ld_n(b_ld_n),
      .a_hiz(a_hiz), .b_hiz(b_hiz), .a_in(a_in), .b_in(b_in),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_word(input string req, input logic [W-1:0] exp);
      check(req, a_out, exp);
      check({req, "/R9"}, b_out, exp);
   endtask

   task automatic check_oe;
      check("R3", a_oe, {W{~a_hiz}});
      check("R4", b_oe, {W{~b_hiz}});
   endtask

   initial begin
      string tag;
      // reset state
      #1;
      check_word("R2", '0);
      a_hiz = 1'b0; b_hiz = 1'b1;
      #0.5;
      check_oe();
      @(negedge clk);
      clr = 1'b0;

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {a_ld_n, b_ld_n, a_hiz, b_hiz, a_in, b_in} = VEC[i][15:4];
         @(posedge clk);
         #1;
         case ({a_ld_n, b_ld_n})
            2'b01:   tag = "R5";
            2'b10:   tag = "R6";
            2'b00:   tag = "R7";
            default: tag = "R8";
         endcase
         check_word(tag, VEC[i][3:0]);
         check_oe();
      end

      // R1: load applied between edges does nothing until the edge
      @(negedge clk);
      a_ld_n = 1'b0; b_ld_n = 1'b1; a_in = 4'b0011;
      #1;
      check_word("R1", 4'b0110);
      @(posedge clk);
      #1;
      check_word("R5", 4'b0011);

      // R2: clear raised mid-cycle, held across an edge with a load pending
      @(negedge clk);
      a_ld_n = 1'b1; b_ld_n = 1'b0; b_in = 4'b1111; a_hiz = 1'b0; b_hiz = 1'b1;
      #0.5;
      clr = 1'b1;
      #0.5;
      check_word("R2", 4'b0000);
      check_oe();
      @(posedge clk);
      #1;
      check_word("R2", 4'b0000);
      @(negedge clk);
      clr = 1'b0;
      @(posedge clk);
      #1;
      check_word("R6", 4'b1111);

      // R7: OR merge where the two buses disagree on every bit
      @(negedge clk);
      a_ld_n = 1'b0; b_ld_n = 1'b0; a_in = 4'b0101; b_in = 4'b1010;
      @(posedge clk);
      #1;
      check_word("R7", 4'b1111);

      // R7: a zero on both buses clears those bits even when the word had them set
      @(negedge clk);
      a_in = 4'b0100; b_in = 4'b0000;
      @(posedge clk);
      #1;
      check_word("R7", 4'b0100);

      // R8: the bus inputs change under hold, and the high-impedance controls flip
      @(negedge clk);
      a_ld_n = 1'b1; b_ld_n = 1'b1; a_in = 4'b1011; b_in = 4'b1101;
      a_hiz = 1'b1; b_hiz = 1'b0;
      @(posedge clk);
      #1;
      check_word("R8", 4'b0100);
      check_oe();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule